// File: doc/BRIEF.md
# Channel Device Initial Selection Sequencer

This block is the channel-side controller for the opening handshake with a device control unit on a parallel byte bus with separate inbound and outbound tag lines. The CPU hands it one of three operations (start, test, or chained command) together with the unit address, command byte, data address and byte count. For a start or chained command, the sequencer drives the unit address with its select tag raised. It then waits for the control unit to return its address or to return status instead.

A returned address that matches the one sent leads to the command phase. The command byte goes out with the command tag and is latched into the channel command register. The data address is then loaded one byte at a time, least significant first. A chained command also loads the byte count and checks it for zero. The sequencer then waits for the initial status byte and answers it with the service tag. A test operation goes straight to that status wait. A mismatched address, an early status (control unit busy), a time-out in either wait, or a zero count ends the operation with its own completion code.

Inbound tags and the inbound bus pass through a two-stage register chain before the controller acts on them. Each wait loop has a programmable cycle limit.

Top module: `chan_init_sel`

## Requirements
- R1: After reset the sequencer is idle: busy, done, out_sel, out_cmd and out_srv are 0, out_bus is 0, result is 0 and both check flags are 0.
- R2: A start (req_op 0) or chained command (req_op 2) enters the select wait. There out_sel is 1 and out_bus holds req_unit, stable for the whole wait.
- R3: An inbound address tag whose bus byte equals the unit address leads to one cycle with out_cmd = 1 and out_bus = req_cmd; chan_cmd then holds req_cmd.
- R4: An inbound address tag whose bus byte differs from the unit address ends the operation with result 3, both check flags 0 and dev_status 0.
- R5: An inbound status tag during the select wait (it takes priority over a simultaneous address tag) ends the operation with result 2 (control unit busy) and dev_status equal to the bus byte.
- R6: After the command cycle, chan_addr is loaded one byte per cycle, low byte first, with req_addr. Two cycles after the command cycle, the low byte is new and the high byte still holds the previous value.
- R7: A test operation (req_op 1) skips selection and goes straight into the status wait; start and chained command reach it after the address load.
- R8: A status tag in the status wait captures the bus byte in dev_status and ends with result 0 if it is zero, else 1; out_srv is 1 in the done cycle.
- R9: With tmo_limit = L > 0, spending L cycles in one wait loop without a tag ends with result 3 and chk_timeout = 1. The counter restarts on every entry into a loop. L = 0 disables the time-out.
- R10: A chained command loads req_count into chan_count. A zero count ends with result 3 and chk_cnt_zero = 1. A non-zero count sets count_ready = 1 and proceeds to the status wait.
- R11: done is a one-cycle strobe. A tag raised by the bench is acted on at the third rising edge after it is driven.
- R12: A request while busy, and a request with req_op 3, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 0 start, 1 test, 2 chained command, 3 reserved |
| req_unit | input | DW | Unit address to select |
| req_cmd | input | DW | Command byte |
| req_addr | input | AB*DW | Data address |
| req_count | input | CW | Byte count (chained command) |
| tmo_limit | input | TW | Wait-loop cycle limit, 0 disables |
| in_bus | input | DW | Inbound bus from control unit |
| in_adr | input | 1 | Inbound address tag |
| in_sta | input | 1 | Inbound status tag |
| out_bus | output | DW | Outbound bus |
| out_sel | output | 1 | Select tag (unit address valid) |
| out_cmd | output | 1 | Command tag |
| out_srv | output | 1 | Service tag answering status |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion strobe |
| result | output | 2 | 0 zero status, 1 status stored, 2 unit busy, 3 check |
| chk_timeout | output | 1 | Check was a wait time-out |
| chk_cnt_zero | output | 1 | Check was a zero byte count |
| dev_status | output | DW | Captured device status |
| chan_cmd | output | DW | Channel command register |
| chan_addr | output | AB*DW | Channel data address register |
| chan_count | output | CW | Channel byte count register |
| count_ready | output | 1 | Non-zero count loaded |

## Verification
Counting the request edge as the first, done is due at edge 3 for a busy unit, a mismatch or a test with status already up. With status returned after the command cycle, it is due at edge 7 for a start and edge 8 for a chained command. A time-out is due L edges after loop entry: 21, 26 and 27 for L = 20. The bench samples one nanosecond after each rising edge. It counts edges from the request until done and compares that count with the figure above for every vector. The command-cycle bus value and the half-loaded data address are sampled in their exact cycles, and the strobe widths are checked on the following cycle.

// File: rtl/cis_pkg.sv
package cis_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_TEST  = 2'd1,
      OP_CHAIN = 2'd2,
      OP_RSVD  = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      RC_ZERO   = 2'd0,
      RC_STORED = 2'd1,
      RC_BUSY   = 2'd2,
      RC_CHECK  = 2'd3
   } rc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_CMD,
      ST_ADR,
      ST_CNT,
      ST_STW,
      ST_FIN
   } st_e;
endpackage

// File: rtl/cis_tag_sync.sv
module cis_tag_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("cis_tag_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[i] <= '0;
            else        pipe[i] <= pipe[i-1];
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/cis_wait_timer.sv
module cis_wait_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          expire
);
   logic [TW-1:0] cnt;

   assign expire = run && (limit != '0) && (cnt == limit - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt <= '0;
      else if (run && !expire) cnt <= cnt + 1'b1;
   end

   // R9: the counter never passes the limit while a limit is set
   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (limit != '0 && $stable(limit) && run) |-> (cnt < limit));
endmodule

// File: rtl/chan_init_sel.sv
module chan_init_sel
   import cis_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AB      = 2,
   parameter int CW      = 16,
   parameter int TW      = 16,
   parameter int STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op,
   input  logic [DW-1:0]    req_unit,
   input  logic [DW-1:0]    req_cmd,
   input  logic [AB*DW-1:0] req_addr,
   input  logic [CW-1:0]    req_count,
   input  logic [TW-1:0]    tmo_limit,
   input  logic [DW-1:0]    in_bus,
   input  logic             in_adr,
   input  logic             in_sta,
   output logic [DW-1:0]    out_bus,
   output logic             out_sel,
   output logic             out_cmd,
   output logic             out_srv,
   output logic             busy,
   output logic             done,
   output logic [1:0]       result,
   output logic             chk_timeout,
   output logic             chk_cnt_zero,
   output logic [DW-1:0]    dev_status,
   output logic [DW-1:0]    chan_cmd,
   output logic [AB*DW-1:0] chan_addr,
   output logic [CW-1:0]    chan_count,
   output logic             count_ready
);
   localparam int AW = AB * DW;
   localparam int IW = (AB > 1) ? $clog2(AB) : 1;
   localparam int SW = DW + 2;

   generate
      if (DW < 1 || AB < 1 || CW < 1 || TW < 1) begin : g_bad
         $error("chan_init_sel: widths must be positive");
      end
   endgenerate

   // synchronised inbound tags and bus
   logic [SW-1:0] sync_q;
   logic [DW-1:0] bus_s;
   logic          adr_s, sta_s;

   cis_tag_sync #(.W(SW), .STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({in_sta, in_adr, in_bus}),
      .q     (sync_q)
   );
   assign {sta_s, adr_s, bus_s} = sync_q;

   st_e           state;
   op_e           op_q;
   rc_e           rc_q;
   logic [DW-1:0] unit_q, cmd_q;
   logic [AW-1:0] addr_src_q;
   logic [CW-1:0] cnt_src_q;
   logic [IW-1:0] byte_idx;
   logic          ack_q;

   logic in_wait, tmr_clear, tmr_run, tmr_expire;
   assign in_wait   = (state == ST_SEL) || (state == ST_STW);
   assign tmr_clear = !in_wait;
   assign tmr_run   = in_wait && !adr_s && !sta_s;

   cis_wait_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (tmr_clear),
      .run    (tmr_run),
      .limit  (tmo_limit),
      .expire (tmr_expire)
   );

   always_comb begin
      unique case (state)
         ST_SEL:  out_bus = unit_q;
         ST_CMD:  out_bus = cmd_q;
         default: out_bus = '0;
      endcase
   end

   assign out_sel = (state == ST_SEL);
   assign out_cmd = (state == ST_CMD);
   assign done    = (state == ST_FIN);
   assign out_srv = done && ack_q;
   assign busy    = (state != ST_IDLE);
   assign result  = rc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         op_q         <= OP_START;
         rc_q         <= RC_ZERO;
         unit_q       <= '0;
         cmd_q        <= '0;
         addr_src_q   <= '0;
         cnt_src_q    <= '0;
         byte_idx     <= '0;
         ack_q        <= 1'b0;
         chk_timeout  <= 1'b0;
         chk_cnt_zero <= 1'b0;
         dev_status   <= '0;
         chan_cmd     <= '0;
         chan_addr    <= '0;
         chan_count   <= '0;
         count_ready  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid && op_e'(req_op) != OP_RSVD) begin
                  op_q         <= op_e'(req_op);
                  unit_q       <= req_unit;
                  cmd_q        <= req_cmd;
                  addr_src_q   <= req_addr;
                  cnt_src_q    <= req_count;
                  rc_q         <= RC_ZERO;
                  ack_q        <= 1'b0;
                  chk_timeout  <= 1'b0;
                  chk_cnt_zero <= 1'b0;
                  dev_status   <= '0;
                  count_ready  <= 1'b0;
                  state        <= (op_e'(req_op) == OP_TEST) ? ST_STW : ST_SEL;
               end
            end
            ST_SEL: begin
               if (sta_s) begin
                  dev_status <= bus_s;
                  rc_q       <= RC_BUSY;
                  ack_q      <= 1'b1;
                  state      <= ST_FIN;
               end else if (adr_s) begin
                  if (bus_s == unit_q) begin
                     state <= ST_CMD;
                  end else begin
                     rc_q  <= RC_CHECK;
                     state <= ST_FIN;
                  end
               end else if (tmr_expire) begin
                  rc_q        <= RC_CHECK;
                  chk_timeout <= 1'b1;
                  state       <= ST_FIN;
               end
            end
            ST_CMD: begin
               chan_cmd <= cmd_q;
               byte_idx <= '0;
               state    <= ST_ADR;
            end
            ST_ADR: begin
               chan_addr[int'(byte_idx)*DW +: DW] <= addr_src_q[int'(byte_idx)*DW +: DW];
               if (byte_idx == IW'(AB-1))
                  state <= (op_q == OP_CHAIN) ? ST_CNT : ST_STW;
               else
                  byte_idx <= byte_idx + 1'b1;
            end
            ST_CNT: begin
               chan_count <= cnt_src_q;
               if (cnt_src_q == '0) begin
                  rc_q         <= RC_CHECK;
                  chk_cnt_zero <= 1'b1;
                  state        <= ST_FIN;
               end else begin
                  count_ready <= 1'b1;
                  state       <= ST_STW;
               end
            end
            ST_STW: begin
               if (sta_s) begin
                  dev_status <= bus_s;
                  rc_q       <= (bus_s == '0) ? RC_ZERO : RC_STORED;
                  ack_q      <= 1'b1;
                  state      <= ST_FIN;
               end else if (tmr_expire) begin
                  rc_q        <= RC_CHECK;
                  chk_timeout <= 1'b1;
                  state       <= ST_FIN;
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R11: completion strobe lasts one cycle
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3: command tag lasts one cycle
   assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_cmd |=> !out_cmd);
   // R2: unit address held steady through the select wait
   assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sel && $past(out_sel)) |-> $stable(out_bus));
   // R8: service tag only answers accepted status
   assert_srv_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_srv |-> (done && result != RC_CHECK));
   // R9: a time-out always reports a check
   assert_timeout_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && chk_timeout) |-> (result == RC_CHECK));
   // R10: a zero count is a check without count ready
   assert_cnt_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && chk_cnt_zero) |-> (result == RC_CHECK && !count_ready));
   // R12: no outbound tag while idle
   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!out_sel && !out_cmd && !out_srv));
endmodule

// File: tb/chan_init_sel_tb.sv
`timescale 1ns/1ps
module chan_init_sel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [7:0]  req_unit = '0, req_cmd = '0;
   logic [15:0] req_addr = '0, req_count = '0;
   logic [15:0] tmo_limit = 16'd20;
   logic [7:0]  in_bus = '0;
   logic        in_adr = 1'b0, in_sta = 1'b0;
   logic [7:0]  out_bus, dev_status, chan_cmd;
   logic        out_sel, out_cmd, out_srv, busy, done, chk_timeout, chk_cnt_zero, count_ready;
   logic [1:0]  result;
   logic [15:0] chan_addr, chan_count;

   int checks = 0;
   int errors = 0;
   logic [15:0] last_addr = '0;

   always #2 clk = ~clk;

   chan_init_sel u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_unit(req_unit), .req_cmd(req_cmd), .req_addr(req_addr),
      .req_count(req_count), .tmo_limit(tmo_limit), .in_bus(in_bus),
      .in_adr(in_adr), .in_sta(in_sta), .out_bus(out_bus), .out_sel(out_sel),
      .out_cmd(out_cmd), .out_srv(out_srv), .busy(busy), .done(done),
      .result(result), .chk_timeout(chk_timeout), .chk_cnt_zero(chk_cnt_zero),
      .dev_status(dev_status), .chan_cmd(chan_cmd), .chan_addr(chan_addr),
      .chan_count(chan_count), .count_ready(count_ready)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // mode: 0 address then status, 1 status (and address) preset, 2 address only, 3 silent
   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  unit;
      logic [7:0]  rsp;
      logic [1:0]  mode;
      logic [7:0]  stat;
      logic [15:0] cnt;
      logic [1:0]  rc;
      logic        to;
      logic        cz;
      logic [7:0]  n;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 8'h12, 8'h12, 2'd0, 8'h00, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd7},
      '{2'd0, 8'h21, 8'h21, 2'd0, 8'h0C, 16'h0000, 2'd1, 1'b0, 1'b0, 8'd7},
      '{2'd0, 8'h33, 8'h33, 2'd1, 8'h10, 16'h0000, 2'd2, 1'b0, 1'b0, 8'd3},
      '{2'd0, 8'h12, 8'h13, 2'd2, 8'h00, 16'h0000, 2'd3, 1'b0, 1'b0, 8'd3},
      '{2'd0, 8'h44, 8'h44, 2'd3, 8'h00, 16'h0000, 2'd3, 1'b1, 1'b0, 8'd21},
      '{2'd0, 8'h45, 8'h45, 2'd2, 8'h00, 16'h0000, 2'd3, 1'b1, 1'b0, 8'd26},
      '{2'd1, 8'h50, 8'h50, 2'd1, 8'h00, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd3},
      '{2'd1, 8'h51, 8'h51, 2'd1, 8'h40, 16'h0000, 2'd1, 1'b0, 1'b0, 8'd3},
      '{2'd2, 8'h60, 8'h60, 2'd0, 8'h00, 16'h0100, 2'd0, 1'b0, 1'b0, 8'd8},
      '{2'd2, 8'h61, 8'h61, 2'd0, 8'h00, 16'h0000, 2'd3, 1'b0, 1'b1, 8'd7},
      '{2'd2, 8'h62, 8'h62, 2'd2, 8'h00, 16'h0005, 2'd3, 1'b1, 1'b0, 8'd27},
      '{2'd1, 8'h70, 8'h70, 2'd3, 8'h00, 16'h0000, 2'd3, 1'b1, 1'b0, 8'd21}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int  n = 0;
      int  k = -1;
      bit  got = 0;
      bit  reached = 0;
      logic [15:0] a = {8'h40 + 8'(idx), v.unit};
      logic [7:0]  c = v.unit ^ 8'hA5;
      if (v.mode == 2'd1) begin in_sta = 1; in_adr = 1; in_bus = v.stat; end
      else if (v.mode != 2'd3) begin in_adr = 1; in_bus = v.rsp; end
      req_valid = 1; req_op = v.op; req_unit = v.unit; req_cmd = c;
      req_addr = a; req_count = v.cnt;
      while (!got && n < 100) begin
         step();
         req_valid = 0;
         n++;
         if (n == 1 && v.op != 2'd1) begin
            check($sformatf("R2 vec%0d select tag", idx), out_sel, 1);
            check($sformatf("R2 vec%0d unit on bus", idx), out_bus, v.unit);
         end
         if (out_cmd && k < 0) begin
            k = 0; reached = 1;
            check($sformatf("R3 vec%0d command byte", idx), out_bus, c);
            if (v.mode == 2'd0) begin in_adr = 0; in_sta = 1; in_bus = v.stat; end
            else in_adr = 0;
         end else if (k >= 0) begin
            k++;
            if (k == 2)
               check($sformatf("R6 vec%0d low byte first", idx), chan_addr, {last_addr[15:8], a[7:0]});
         end
         if (done) got = 1;
      end
      check($sformatf("R11 vec%0d done edge count", idx), n, v.n);
      check($sformatf("R4 R5 R8 vec%0d result", idx), result, v.rc);
      check($sformatf("R9 vec%0d timeout flag", idx), chk_timeout, v.to);
      check($sformatf("R10 vec%0d count zero flag", idx), chk_cnt_zero, v.cz);
      check($sformatf("R8 vec%0d service tag", idx), out_srv, (v.rc != 2'd3));
      check($sformatf("R5 R8 vec%0d status", idx), dev_status, (v.rc != 2'd3) ? v.stat : 8'h00);
      check($sformatf("R10 vec%0d count ready", idx), count_ready, (v.op == 2'd2 && v.cnt != 0 && reached));
      if (reached) begin
         check($sformatf("R3 vec%0d command register", idx), chan_cmd, c);
         if (!(v.op == 2'd2 && v.to == 1'b0 && v.cz == 1'b0 && v.rc == 2'd3))
            check($sformatf("R6 vec%0d data address", idx), chan_addr, a);
         if (v.op == 2'd2) check($sformatf("R10 vec%0d count register", idx), chan_count, v.cnt);
         last_addr = a;
      end
      in_adr = 0; in_sta = 0; in_bus = 0;
      step();
      check($sformatf("R11 vec%0d strobe width", idx), done, 0);
      repeat (4) step();
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 tags", {out_sel, out_cmd, out_srv}, 0);
      check("R1 bus", out_bus, 0);
      check("R1 result and flags", {result, chk_timeout, chk_cnt_zero}, 0);
      rst_n = 1;
      repeat (2) step();

      for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

      // R12 reserved operation ignored
      req_valid = 1; req_op = 2'd3; req_unit = 8'h99;
      step(); req_valid = 0;
      repeat (3) step();
      check("R12 reserved op stays idle", busy, 0);

      // R12 request while busy ignored; R9 select time-out
      req_valid = 1; req_op = 2'd0; req_unit = 8'h55;
      step(); req_valid = 0;
      repeat (3) step();
      req_valid = 1; req_op = 2'd1; req_unit = 8'h77;
      step(); req_valid = 0;
      check("R12 unit kept while busy", out_bus, 8'h55);
      check("R12 still selecting", out_sel, 1);
      repeat (40) begin if (!done) step(); end
      check("R9 select time-out", {done, result, chk_timeout}, {1'b1, 2'd3, 1'b1});
      repeat (4) step();

      // R9 limit 0 disables the time-out
      tmo_limit = 16'd0;
      req_valid = 1; req_op = 2'd1; req_unit = 8'h10;
      step(); req_valid = 0;
      repeat (60) step();
      check("R9 no time-out when limit is 0", {busy, done}, 2'b10);
      in_sta = 1; in_bus = 8'h00;
      repeat (3) step();
      check("R7 R8 test finishes on status", {done, result, out_srv}, {1'b1, 2'd0, 1'b1});
      in_sta = 0;
      step();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule